// File: doc/BRIEF.md
# Dual-Input Program Command Receiver

This block is the serial front end that accepts a page-program command for a flash-style storage device. While chip select is held low, it samples one bit on each rising serial clock. The first eight bits form the command code and the next twenty-four bits form the start address. Both arrive most significant bit first on `io0`. When the code is the dual-input program code, the block then takes two bits on every rising serial clock, one from each of the two data pins. Each completed byte goes out with a one-cycle strobe and the array address it belongs to. That address wraps inside the 256-byte page of the start address.

When chip select returns high, the block judges the whole transfer. A transfer that is complete, ends on a byte boundary, targets an unprotected sector and began with the write-enable latch set produces a one-cycle commit pulse. The pulse carries the start address and the byte count. Any other ending of a matched command that began with the latch set produces a one-cycle abort pulse. Both endings clear the write-enable latch.

The serial inputs are sampled in the system clock domain. The serial clock must stay low and high for at least one system clock each.

Top module: `dual_prog_rx`

## Requirements
- R1: After synchronous reset, `wel` is 0 and `commit`, `cmd_abort` and `byte_valid` are all 0.
- R2: While `cs_n` is low, each rising `sck` shifts one bit from `io0`, MSB first. The first 8 bits are the command code, and code A2h selects dual-input program. The next 24 bits are the start address, bit 23 first.
- R3: After the 32 header bits, each rising `sck` takes two data bits: `io1` is the higher bit and `io0` the lower. The first pair is bits 7:6 of a byte, so four rising edges complete it. `byte_valid` is high for one cycle, in the cycle after the fourth edge is sampled, with `byte_data` holding the byte.
- R4: `byte_addr` for the k-th byte (counting from 0) keeps bits 23:8 of the start address. Its bits 7:0 are the start address bits 7:0 plus k, modulo 256.
- R5: When `cs_n` rises on a byte boundary after at least one data byte, and `wel` was 1 when `cs_n` fell, `commit` is high for one cycle. It carries `commit_addr` equal to the start address and `commit_count` equal to the number of bytes sent. The sector must be unprotected. `wel` goes to 0 in the same cycle.
- R6: When more than 256 data bytes are sent, `commit_count` is 256.
- R7: When `cs_n` rises after a matched code but before the address and one full data byte have arrived, `cmd_abort` pulses instead of `commit` and `wel` clears.
- R8: When `cs_n` rises after a data pin pair count that is not a multiple of four, `cmd_abort` pulses and `wel` clears.
- R9: `prot_map` bit i protects the sector whose address bits 23:16 equal i. A command whose start address lies in a protected sector gives no byte strobes. At `cs_n` rise it pulses `cmd_abort` and clears `wel`.
- R10: A dual-input program command that starts while `wel` is 0 gives no byte strobes, no commit and no abort.
- R11: A code other than A2h is ignored: no strobes, no commit, no abort, and `wel` keeps its value.
- R12: `wel_set` sets `wel` to 1. `sck` edges while `cs_n` is high have no effect, and the next command decodes normally.
- R13: `commit` and `cmd_abort` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled by `clk` |
| io0 | input | 1 | Header bit input, lower data bit |
| io1 | input | 1 | Upper data bit |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| prot_map | input | 256 | One protection bit per sector |
| wel | output | 1 | Write-enable latch |
| byte_valid | output | 1 | One-cycle strobe for an assembled data byte |
| byte_data | output | 8 | Assembled data byte |
| byte_addr | output | 24 | Page-wrapped array address of the byte |
| commit | output | 1 | One-cycle pulse: program the buffered page |
| commit_addr | output | 24 | Start address of the committed command |
| commit_count | output | 9 | Bytes to program, 1 to 256 |
| cmd_abort | output | 1 | One-cycle pulse: command abandoned |

## Verification
The hardest case to reach is a transfer longer than one page that starts mid-page. It drives both the address wrap and the saturation of the byte count. The stimulus sends 300 bytes from an offset of 80h, so the index rolls past the page end and then passes 256 before chip select rises. A second hard case is a chip-select release one data pair after a byte boundary, which needs the header and two full bytes to be sent first. Each of these, and every other scenario, is compared on every clock against a behavioural model that keeps its own bit, pair and byte counters.

// File: rtl/dprx_pkg.sv
package dprx_pkg;

    localparam int          OPC_W         = 8;
    localparam logic [7:0]  OPC_DUAL_PROG = 8'hA2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        END_COMMIT,
        END_SHORT,
        END_MISALIGN,
        END_PROT
    } end_e;

    // Outcome of a matched command when chip select is released.
    function automatic end_e verdict(input logic hdr_done, input logic have_byte,
                                     input logic aligned, input logic prot);
        if (!hdr_done || !have_byte) return END_SHORT;
        if (!aligned)                return END_MISALIGN;
        if (prot)                    return END_PROT;
        return END_COMMIT;
    endfunction

endpackage

// File: rtl/dprx_edges.sv
module dprx_edges (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise
);
    logic cs_q;
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
        end
    end

    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    // Serial clock edges only count while the device is selected.
    assign sck_rise = sck & ~sck_q & ~cs_n;

endmodule

// File: rtl/dprx_shift.sv
module dprx_shift
    import dprx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              io0,
    input  logic              io1,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr,
    output logic [PAGE_W:0]   nbytes,
    output logic              aligned,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam int             HDR_BITS  = OPC_W + ADDR_W;
    localparam int             CNT_W     = $clog2(HDR_BITS + 1);
    localparam logic [PAGE_W:0] MAX_BYTES = (PAGE_W + 1)'(1) << PAGE_W;

    logic [CNT_W-1:0]  hcnt;
    logic [6:0]        opc_sh;
    logic [1:0]        pair;
    logic [5:0]        dsh;
    logic [PAGE_W-1:0] widx;
    logic [7:0]        opc_next;

    assign opc_next = {opc_sh, io0};
    assign aligned  = (pair == 2'd0);

    always_ff @(posedge clk) begin
        byte_valid <= 1'b0;
        if (rst) begin
            phase     <= PH_IDLE;
            hcnt      <= '0;
            opc_sh    <= '0;
            addr      <= '0;
            pair      <= '0;
            dsh       <= '0;
            widx      <= '0;
            nbytes    <= '0;
            byte_data <= '0;
            byte_addr <= '0;
        end else if (cs_fall) begin
            phase  <= PH_OPC;
            hcnt   <= '0;
            pair   <= '0;
            widx   <= '0;
            nbytes <= '0;
        end else if (cs_rise) begin
            phase <= PH_IDLE;
        end else if (sck_rise) begin
            unique case (phase)
                PH_OPC: begin
                    opc_sh <= opc_next[6:0];
                    hcnt   <= hcnt + CNT_W'(1);
                    if (hcnt == CNT_W'(OPC_W - 1))
                        phase <= (opc_next == OPC_DUAL_PROG) ? PH_ADDR : PH_IDLE;
                end
                PH_ADDR: begin
                    addr <= {addr[ADDR_W-2:0], io0};
                    hcnt <= hcnt + CNT_W'(1);
                    if (hcnt == CNT_W'(HDR_BITS - 1))
                        phase <= PH_DATA;
                end
                PH_DATA: begin
                    dsh  <= {dsh[3:0], io1, io0};
                    pair <= pair + 2'd1;
                    if (pair == 2'd3) begin
                        byte_valid <= 1'b1;
                        byte_data  <= {dsh, io1, io0};
                        byte_addr  <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + widx};
                        widx       <= widx + PAGE_W'(1);
                        if (nbytes != MAX_BYTES)
                            nbytes <= nbytes + (PAGE_W + 1)'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: bytes need four serial edges, so strobes never come back to back
    a_r3_byte_spacing: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R6: the byte count never passes one page
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        nbytes <= MAX_BYTES);

    // R2: data phase is only entered from the address phase
    a_r2_data_after_addr: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_ADDR);

endmodule

// File: rtl/dprx_judge.sv
module dprx_judge
    import dprx_pkg::*;
#(
    parameter  int ADDR_W  = 24,
    parameter  int PAGE_W  = 8,
    parameter  int SECT_LO = 16,
    localparam int NSECT   = 1 << (ADDR_W - SECT_LO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              wel_set,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W:0]   nbytes,
    input  logic              aligned,
    input  logic [NSECT-1:0]  prot_map,
    output logic              wel,
    output logic              take,
    output logic              commit,
    output logic              cmd_abort,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [PAGE_W:0]   commit_count
);
    localparam logic [PAGE_W:0] MAX_BYTES = (PAGE_W + 1)'(1) << PAGE_W;

    logic wel_start;
    logic prot;
    logic matched;
    end_e outcome;

    assign prot    = prot_map[addr[ADDR_W-1:SECT_LO]];
    assign matched = (phase == PH_ADDR) || (phase == PH_DATA);
    assign outcome = verdict(phase == PH_DATA, nbytes != '0, aligned, prot);
    assign take    = wel_start && (phase == PH_DATA) && !prot;

    always_ff @(posedge clk) begin
        commit    <= 1'b0;
        cmd_abort <= 1'b0;
        if (rst) begin
            wel          <= 1'b0;
            wel_start    <= 1'b0;
            commit_addr  <= '0;
            commit_count <= '0;
        end else begin
            if (cs_fall)
                wel_start <= wel;
            if (cs_rise && matched && wel_start) begin
                wel <= 1'b0;
                if (outcome == END_COMMIT) begin
                    commit       <= 1'b1;
                    commit_addr  <= addr;
                    commit_count <= nbytes;
                end else begin
                    cmd_abort <= 1'b1;
                end
            end else if (wel_set) begin
                wel <= 1'b1;
            end
        end
    end

    // R13: one outcome per command
    a_r13_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(commit && cmd_abort));

    // R5 / R7: every ending of an accepted command leaves the latch clear
    a_r5_latch_cleared: assert property (@(posedge clk) disable iff (rst)
        (commit || cmd_abort) |-> !wel);

    // R10: a commit is only possible if the latch was set beforehand
    a_r10_commit_needs_latch: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(wel));

    // R6: committed count lies in 1..page size
    a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
        commit |-> (commit_count != '0 && commit_count <= MAX_BYTES));

endmodule

// File: rtl/dual_prog_rx.sv
module dual_prog_rx
    import dprx_pkg::*;
#(
    parameter  int ADDR_W  = 24,
    parameter  int PAGE_W  = 8,
    parameter  int SECT_LO = 16,
    localparam int NSECT   = 1 << (ADDR_W - SECT_LO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              io0,
    input  logic              io1,
    input  logic              wel_set,
    input  logic [NSECT-1:0]  prot_map,
    output logic              wel,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [PAGE_W:0]   commit_count,
    output logic              cmd_abort
);
    logic              cs_fall;
    logic              cs_rise;
    logic              sck_rise;
    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    logic [PAGE_W:0]   nbytes;
    logic              aligned;
    logic              raw_valid;
    logic              take;

    dprx_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck      (sck),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise)
    );

    dprx_shift #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sck_rise   (sck_rise),
        .io0        (io0),
        .io1        (io1),
        .phase      (phase),
        .addr       (addr),
        .nbytes     (nbytes),
        .aligned    (aligned),
        .byte_valid (raw_valid),
        .byte_data  (byte_data),
        .byte_addr  (byte_addr)
    );

    dprx_judge #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_LO(SECT_LO)) u_judge (
        .clk          (clk),
        .rst          (rst),
        .cs_fall      (cs_fall),
        .cs_rise      (cs_rise),
        .wel_set      (wel_set),
        .phase        (phase),
        .addr         (addr),
        .nbytes       (nbytes),
        .aligned      (aligned),
        .prot_map     (prot_map),
        .wel          (wel),
        .take         (take),
        .commit       (commit),
        .cmd_abort    (cmd_abort),
        .commit_addr  (commit_addr),
        .commit_count (commit_count)
    );

    // Strobes only leave the block for an accepted, unprotected command (R9, R10).
    assign byte_valid = raw_valid & take;

    // R1: nothing is emitted while the device is deselected and idle after reset
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (byte_valid) |-> !cs_n || $past(!cs_n));

endmodule

// File: tb/dual_prog_rx_tb.sv
module dual_prog_rx_tb;
    localparam int ADDR_W = 24;
    localparam int PAGE_W = 8;
    localparam int NSECT  = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, io0 = 1'b0, io1 = 1'b0, wel_set = 1'b0;
    logic [NSECT-1:0]  prot_map;
    logic              wel, byte_valid, commit, cmd_abort;
    logic [7:0]        byte_data;
    logic [ADDR_W-1:0] byte_addr, commit_addr;
    logic [PAGE_W:0]   commit_count;

    always #2 clk = ~clk;

    dual_prog_rx u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .io0(io0), .io1(io1),
        .wel_set(wel_set), .prot_map(prot_map), .wel(wel),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_addr(byte_addr),
        .commit(commit), .commit_addr(commit_addr), .commit_count(commit_count),
        .cmd_abort(cmd_abort)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string req = "R1";

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_prev_cs = 1'b1, m_prev_sck = 1'b0;
    bit          m_wel = 1'b0, m_wel_start = 1'b0, m_active = 1'b0, m_clr = 1'b0;
    int          m_hbits = 0, m_pairs = 0, m_sent = 0;
    int unsigned m_hdr = 0;
    bit [7:0]    m_cur = 0;
    bit          e_commit = 0, e_abort = 0, e_bv = 0;
    int          e_caddr = 0, e_ccount = 0, e_bdata = 0, e_baddr = 0;

    always @(posedge clk) begin
        cycles++;
        e_commit = 0; e_abort = 0; e_bv = 0;
        if (rst) begin
            m_prev_cs = 1; m_prev_sck = 0; m_wel = 0; m_wel_start = 0; m_active = 0; m_clr = 0;
        end else begin
            if (!cs_n && m_prev_cs) begin
                m_active = 1; m_hbits = 0; m_pairs = 0; m_sent = 0; m_hdr = 0;
                m_wel_start = m_wel;
            end else if (cs_n && !m_prev_cs) begin
                if (m_active && m_hbits >= 8 && m_wel_start) begin
                    m_clr = 1;
                    if (m_hbits < 32 || m_sent == 0 || (m_pairs % 4) != 0 ||
                        prot_map[m_hdr[23:16]])
                        e_abort = 1;
                    else begin
                        e_commit = 1;
                        e_caddr  = int'(m_hdr[23:0]);
                        e_ccount = (m_sent > 256) ? 256 : m_sent;
                    end
                end
                m_active = 0;
            end else if (sck && !m_prev_sck && !cs_n && m_active) begin
                if (m_hbits < 32) begin
                    m_hdr = (m_hdr << 1) | int'(io0);
                    m_hbits++;
                    if (m_hbits == 8 && m_hdr != 32'hA2) m_active = 0;
                end else begin
                    m_cur = {m_cur[5:0], io1, io0};
                    m_pairs++;
                    if (m_pairs % 4 == 0) begin
                        if (m_wel_start && !prot_map[m_hdr[23:16]]) begin
                            e_bv    = 1;
                            e_bdata = int'(m_cur);
                            e_baddr = int'(m_hdr & 32'hFFFF00) | int'((m_hdr + m_sent) & 32'hFF);
                        end
                        m_sent++;
                    end
                end
            end
            if (m_clr) m_wel = 0;
            else if (wel_set) m_wel = 1;
            m_clr = 0;
            m_prev_cs = cs_n; m_prev_sck = sck;
        end
    end

    // Compare on every clock, half a period after the edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(req, "wel", int'(wel), int'(m_wel));
            chk(req, "commit", int'(commit), int'(e_commit));
            chk(req, "cmd_abort", int'(cmd_abort), int'(e_abort));
            chk(req, "byte_valid", int'(byte_valid), int'(e_bv));
            chk("R13", "commit&abort", int'(commit && cmd_abort), 0);
            if (e_bv) begin
                chk(req, "byte_data", int'(byte_data), e_bdata);
                chk(req, "byte_addr", int'(byte_addr), e_baddr);
            end
            if (e_commit) begin
                chk(req, "commit_addr", int'(commit_addr), e_caddr);
                chk(req, "commit_count", int'(commit_count), e_ccount);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog %s: actual %0d cycles expected completion", req, cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_pair(bit b1, bit b0);
        io1 = b1; io0 = b0; sck = 0;
        tick(2);
        sck = 1;
        tick(2);
        sck = 0;
    endtask

    task automatic pulse_wel();
        wel_set = 1; tick(1); wel_set = 0; tick(1);
    endtask

    task automatic send(logic [7:0] opc, logic [23:0] a, int nhdr, int nbytes,
                        int extra, logic [7:0] seed);
        logic [31:0] h;
        h = {opc, a};
        cs_n = 0; tick(2);
        for (int i = 0; i < nhdr; i++) clk_pair(1'b0, h[31-i]);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] b;
            b = 8'(int'(seed) + k * 37);
            for (int j = 0; j < 4; j++) clk_pair(b[7-2*j], b[6-2*j]);
        end
        for (int j = 0; j < extra; j++) clk_pair(1'b1, 1'b0);
        tick(1); cs_n = 1; tick(4);
    endtask

    initial begin
        prot_map = '0;
        prot_map[8'h40] = 1'b1;
        tick(3);
        // R1: reset state
        chk("R1", "wel in reset", int'(wel), 0);
        chk("R1", "commit in reset", int'(commit), 0);
        chk("R1", "abort in reset", int'(cmd_abort), 0);
        chk("R1", "byte_valid in reset", int'(byte_valid), 0);
        rst = 0; tick(3);

        // R4 (with R2, R3, R5): start at FEh of a page, three bytes wrap to offset 0
        req = "R4"; pulse_wel(); send(8'hA2, 24'h0012FE, 32, 3, 0, 8'h11);
        // R5: plain commit, aligned start
        req = "R5"; pulse_wel(); send(8'hA2, 24'h123400, 32, 5, 0, 8'h5A);
        // R3: byte patterns that exercise both data pins
        req = "R3"; pulse_wel(); send(8'hA2, 24'h00AB10, 32, 4, 0, 8'hC3);
        // R6: 300 bytes from mid-page
        req = "R6"; pulse_wel(); send(8'hA2, 24'h010080, 32, 300, 0, 8'h03);
        // R7: release inside the address, then right after the address
        req = "R7"; pulse_wel(); send(8'hA2, 24'h020000, 20, 0, 0, 8'h00);
        pulse_wel(); send(8'hA2, 24'h020000, 32, 0, 0, 8'h00);
        // R8: two bytes and one extra pair
        req = "R8"; pulse_wel(); send(8'hA2, 24'h030010, 32, 2, 1, 8'h77);
        // R9: protected sector 40h
        req = "R9"; pulse_wel(); send(8'hA2, 24'h401000, 32, 4, 0, 8'h21);
        // R10: latch is clear here
        req = "R10"; send(8'hA2, 24'h050000, 32, 4, 0, 8'h44);
        // R11: other code, latch stays set
        req = "R11"; pulse_wel(); send(8'h02, 24'h060000, 32, 2, 0, 8'h99);
        // R12: serial clock while deselected, then a normal command
        req = "R12";
        for (int i = 0; i < 10; i++) begin sck = 1; tick(2); sck = 0; tick(2); end
        send(8'hA2, 24'h00FF00, 32, 2, 0, 8'hE0);

        tick(5);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule